// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands one radix-4 digit at a time. The partial product and the multiplicand `B` sit in registers, and one adder is reused for every step. A single `load` pulse captures both operands and starts a run. After that, the block walks through the multiplier operand two bits at a time. Each step examines a three-bit window: the two low bits of the running product plus the bit that was shifted out last. From that window it picks zero, plus or minus `B`, or plus or minus twice `B`. It adds the pick to the upper half of the product and then shifts the whole register right by two places.

Each step takes two clocks. On the first clock the window is recoded into three registered controls: double, negate and zero. On the second clock the adder result is captured and shifted. Negation inverts the selected value and feeds a carry of one into the adder. With the default 8-bit operands there are four steps, and a whole multiply occupies ten clock cycles, counting the cycle that accepts `load`. A free-running half-rate phase decides when a start is allowed. Only even-phase cycles may start a run, and the first cycle after reset is an even phase.

Top module: `booth_mult_seq`

## Requirements
- R1: While and directly after synchronous reset, `product` is zero and `done` is low.
- R2: `load` is accepted only on an even-phase cycle while no run is in progress. Phase alternates every clock, starting even on the first clock after reset. An accepted `load` captures `a_in` and `b_in`.
- R3: `load` is accepted at clock edge k. Then at edge k+9 `product` becomes the signed product `a_in * b_in` as a 16-bit two's-complement value, and `done` rises. `done` is low after edges k+1 to k+8.
- R4: `done` stays high for exactly one cycle. `product` keeps its value until the next run completes.
- R5: A `load` raised while a run is in progress is ignored, at any phase. The running result is unchanged and no extra run follows.
- R6: A `load` raised during an odd-phase cycle while idle is ignored. No run starts, `done` stays low and `product` is unchanged.
- R7: Operands at the range limits give exact results. These include a multiplicand of -128, whose doubled negation is +256, and a multiplier of -128.
- R8: A new `load` may be accepted in the same cycle in which `done` is high. Runs can then follow back to back every ten cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start request; captures operands when accepted |
| a_in | input | 8 | Signed multiplier operand |
| b_in | input | 8 | Signed multiplicand operand |
| product | output | 16 | Registered signed product of the last completed run |
| done | output | 1 | One-cycle pulse when `product` has just been updated |

## Verification
A wrong recode window, a missing carry-in on negation, or a shift that is not sign-preserving all corrupt the partial product. The error appears in `product` when `done` rises nine edges after acceptance. Operand sweeps that include the extremes, signs and alternating bit patterns catch these faults. A sequencer fault shows up as `done` arriving early or late, or lasting more than one cycle. Wrong accept gating shows up as a spurious `done`, or as a corrupted result after a `load` that should have been ignored. Both are visible within the same ten-cycle window.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic two;
    logic neg;
    logic zero;
  } booth_sel_t;

  function automatic booth_sel_t booth_recode(input logic [2:0] win);
    booth_sel_t s;
    s = '{two: 1'b0, neg: 1'b0, zero: 1'b0};
    case (win)
      3'b000, 3'b111: s.zero = 1'b1;
      3'b001, 3'b010: ;
      3'b011:         s.two  = 1'b1;
      3'b100: begin   s.two  = 1'b1; s.neg = 1'b1; end
      default:        s.neg  = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic accept,
  output logic recode_en,
  output logic add_en,
  output logic fin_en,
  output logic done
);
  localparam int LAST = W + 1;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          idle;

  assign idle      = (cnt_q == '0);
  assign accept    = load && !ph_q && idle;
  assign recode_en = !idle && (cnt_q != CW'(LAST)) && cnt_q[0];
  assign add_en    = !idle && !cnt_q[0];
  assign fin_en    = (cnt_q == CW'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      done <= fin_en;
      if (accept)      cnt_q <= CW'(1);
      else if (fin_en) cnt_q <= '0;
      else if (!idle)  cnt_q <= cnt_q + CW'(1);
    end
  end

  // R2: a run begins only after an even-phase load
  a_r2_start_even: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(1)) |-> ($past(load) && !$past(ph_q)));

  // R5: a run in progress advances one step per clock whatever load does
  a_r5_busy_advance: assert property (@(posedge clk) disable iff (rst)
    (!idle && !fin_en) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [2:0] win,
  output booth_sel_t sel
);
  always_ff @(posedge clk) begin
    if (rst || clr) sel <= '{two: 1'b0, neg: 1'b0, zero: 1'b1};
    else if (en)    sel <= booth_recode(win);
  end

  // R7: a zero selection never doubles or negates
  a_r7_sel_legal: assert property (@(posedge clk) disable iff (rst)
    sel.zero |-> (!sel.two && !sel.neg));

endmodule

// File: rtl/booth_addshift.sv
module booth_addshift
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           accept,
  input  logic           add_en,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  booth_sel_t     sel,
  output logic [2:0]     win,
  output logic [2*W-1:0] prod
);
  localparam int HW = W + 2;

  logic [HW-1:0] hi_q;
  logic [W-1:0]  lo_q;
  logic [W-1:0]  b_q;
  logic          prev_q;
  logic [HW-1:0] bext, mag, pick, addend, sum;

  assign bext   = {{2{b_q[W-1]}}, b_q};
  assign mag    = sel.two ? (bext << 1) : bext;
  assign pick   = sel.zero ? '0 : mag;
  assign addend = sel.neg ? ~pick : pick;
  assign sum    = hi_q + addend + HW'(sel.neg);

  assign win  = {lo_q[1:0], prev_q};
  assign prod = {hi_q[W-1:0], lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      b_q    <= '0;
      prev_q <= 1'b0;
    end else if (accept) begin
      hi_q   <= '0;
      lo_q   <= a_in;
      b_q    <= b_in;
      prev_q <= 1'b0;
    end else if (add_en) begin
      hi_q   <= {{2{sum[HW-1]}}, sum[HW-1:2]};
      lo_q   <= {sum[1:0], lo_q[W-1:2]};
      prev_q <= lo_q[1];
    end
  end

  // R7: a zero selection leaves the upper partial product unchanged
  a_r7_zero_passes: assert property (@(posedge clk) disable iff (rst)
    (add_en && sel.zero) |-> (sum == hi_q));

  // R3: an add step shifts the old bit 1 into the recode history bit
  a_r3_history: assert property (@(posedge clk) disable iff (rst)
    (add_en && !accept) |=> (prev_q == $past(lo_q[1])));

endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [2*W-1:0] product,
  output logic           done
);
  logic           accept, recode_en, add_en, fin_en;
  logic [2:0]     win;
  logic [2*W-1:0] prod_w;
  booth_sel_t     sel;

  initial begin
    assert (W >= 2 && W % 2 == 0)
      else $error("operand width must be even");
  end

  booth_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .load(load), .accept(accept),
    .recode_en(recode_en), .add_en(add_en), .fin_en(fin_en), .done(done)
  );

  booth_recoder u_rec (
    .clk(clk), .rst(rst), .clr(accept), .en(recode_en), .win(win), .sel(sel)
  );

  booth_addshift #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .add_en(add_en),
    .a_in(a_in), .b_in(b_in), .sel(sel), .win(win), .prod(prod_w)
  );

  always_ff @(posedge clk) begin
    if (rst)         product <= '0;
    else if (fin_en) product <= prod_w;
  end

  // R4: the product only changes when a run completes
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(fin_en) |-> $stable(product));

endmodule

// File: tb/booth_mult_seq_tb.sv
`timescale 1ns/1ps
module booth_mult_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [7:0]  a_in = '0, b_in = '0;
  logic [15:0] product;
  logic        done;
  int          nedge = 0;
  int          n_run = 0, n_fail = 0;
  logic [15:0] last;

  always #2.5 clk = ~clk;

  booth_mult_seq u_dut (
    .clk(clk), .rst(rst), .load(load), .a_in(a_in), .b_in(b_in),
    .product(product), .done(done)
  );

  always @(posedge clk) nedge <= rst ? 0 : nedge + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  // called at a negedge with nedge even; returns at negedge after edge k+9
  task automatic run_mul(input logic [7:0] a, input logic [7:0] b, input string req);
    load = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    load = 1'b0;
    repeat (8) @(negedge clk);
    chk(done == 1'b0, "R3", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R3", done, 1);
    chk(product == ref_mul(a, b), req, product, ref_mul(a, b));
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] bset [16];
    bset = '{8'h80, 8'h81, 8'hC0, 8'hFE, 8'hFF, 8'h00, 8'h01, 8'h02,
             8'h03, 8'h05, 8'h3F, 8'h40, 8'h55, 8'hAA, 8'h7E, 8'h7F};
    repeat (3) @(negedge clk);
    chk(product == 16'h0 && done == 1'b0, "R1", product, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(product == 16'h0 && done == 1'b0, "R1", product, 0);
    while (nedge % 2 != 0) @(negedge clk);

    // R3 R7 R8: back-to-back near-exhaustive sweep
    for (int j = 0; j < 16; j++)
      for (int i = 0; i < 256; i++)
        run_mul(8'(i), bset[j], (j == 0 || i == 128) ? "R7" : "R8");

    // R4: done pulse is one cycle, product held
    last = product;
    @(negedge clk);
    chk(done == 1'b0, "R4", done, 0);
    chk(product == last, "R4", product, last);
    while (nedge % 2 != 0) @(negedge clk);

    // R5: loads while busy are ignored
    load = 1'b1; a_in = 8'd57; b_in = 8'hD3;
    @(negedge clk);
    load = 1'b0; a_in = 8'h11; b_in = 8'h22;
    repeat (3) @(negedge clk);
    load = 1'b1; a_in = 8'h80; b_in = 8'h80;
    repeat (2) @(negedge clk);
    load = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R5", done, 0);
    @(negedge clk);
    chk(done == 1'b1, "R5", done, 1);
    chk(product == ref_mul(8'd57, 8'hD3), "R5", product, ref_mul(8'd57, 8'hD3));
    last = product;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(done == 1'b0 && product == last, "R5", product, last);
    end

    // R6: odd-phase load while idle is ignored
    while (nedge % 2 == 0) @(negedge clk);
    load = 1'b1; a_in = 8'h7F; b_in = 8'h7F;
    @(negedge clk);
    load = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(done == 1'b0 && product == last, "R6", product, last);
    end

    // R2: even-phase load after idle starts a run
    while (nedge % 2 != 0) @(negedge clk);
    run_mul(8'h80, 8'h80, "R2");
    run_mul(8'h7F, 8'h81, "R7");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule